// File: doc/BRIEF.md
# Power-On Jump NOP Injector

After reset this block makes a processor fetch a stream of no-operation bytes while the memory data path stays switched off. The processor's program counter advances one fetch at a time. The block watches the upper bits of the fetch address. When those bits equal a small configuration value, the block hands the data bus back to memory. In effect the processor jumps to the configured address region without a jump instruction in memory.

The handover decision is registered in two steps. First, a synchronizing register samples the equality result. It records a hit only when the address-valid strobe is high in the cycle it samples. Second, a sticky flag takes that registered hit. A short false equality can appear while address lines switch, for example a nibble moving from 9 to A and passing through B. If the strobe is low during that switching, the false match cannot end the injection. The extra register delays the handover by one system clock. This shortens the access time left for the first real fetch.

Top module: `pj_nop_inject`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `cpu_dout_o` is 8'h00 and `bus_en_o` is 0.
- R2: While the handover flag is clear, `cpu_dout_o` holds 8'h00 (the no-operation byte) and `bus_en_o` is 0, whatever value `mem_din_i` carries.
- R3: A hit is sampled on a clock edge when `addr_vld_i` is 1 and `addr_i[15:12]` equals `cfg_i[3:0]`. No other bits of the address are compared.
- R4: An equal upper nibble presented while `addr_vld_i` is 0 is ignored and never sets the flag.
- R5: A valid matching address driven before edge N gives `bus_en_o` = 1 after edge N+1, and not before. That is exactly two clock edges after the address is presented.
- R6: Once set, the flag stays set for any later address, strobe or configuration value. Only a reset clears it.
- R7: While the flag is set, `cpu_dout_o` equals the `mem_din_i` value sampled at the previous clock edge.
- R8: `bus_en_o` and the data-source switch of `cpu_dout_o` change on the same clock edge. No cycle drives memory data with `bus_en_o` low, and no cycle drives the NOP byte with `bus_en_o` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | 16 | Processor fetch address |
| addr_vld_i | input | 1 | High when `addr_i` is settled and may be compared |
| cfg_i | input | 4 | Target value for the upper address nibble |
| mem_din_i | input | 8 | Data from the memory path |
| cpu_dout_o | output | 8 | Registered data presented to the processor |
| bus_en_o | output | 1 | Enable for the normal memory bus path |

## Verification
The bench builds the block with its default parameters: a 16-bit address, a 4-bit configuration value, an 8-bit data path and a zero no-operation byte. With these values every one of the sixteen configuration codes can be tried in a short run. The nibble sequence 9, B, A can be driven with the strobe low during the false B, and the lower twelve address bits can be toggled to show they play no part. A behavioural model is compared with the outputs on every clock. Directed checks cover the exact two-edge handover latency, the sticky flag, and a second reset.

// File: rtl/pj_pkg.sv
package pj_pkg;

    localparam int DEF_ADDR_W = 16;
    localparam int DEF_CFG_W  = 4;
    localparam int DEF_DATA_W = 8;

    // Data-source mode of the processor data bus
    typedef enum logic {
        MODE_INJECT = 1'b0,
        MODE_PASS   = 1'b1
    } bus_mode_e;

    function automatic logic is_pass(input bus_mode_e m);
        return (m == MODE_PASS);
    endfunction

endpackage

// File: rtl/pj_cmp_sync.sv
module pj_cmp_sync #(
    parameter int ADDR_W = pj_pkg::DEF_ADDR_W,
    parameter int CFG_W  = pj_pkg::DEF_CFG_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              addr_vld_i,
    input  logic [CFG_W-1:0]  cfg_i,
    output logic              hit_q_o
);
    localparam int TAG_LO = ADDR_W - CFG_W;

    logic [CFG_W-1:0] tag;
    logic             raw_eq;

    assign tag    = addr_i[ADDR_W-1:TAG_LO];
    assign raw_eq = (tag == cfg_i);

    // Synchronizing register: raw equality is only trusted inside the valid window
    always_ff @(posedge clk) begin
        if (rst) hit_q_o <= 1'b0;
        else     hit_q_o <= raw_eq & addr_vld_i;
    end

    AST_HIT_NEEDS_VLD: assert property (@(posedge clk) disable iff (rst)
        hit_q_o |-> $past(addr_vld_i)); // R4

    AST_HIT_NEEDS_EQ: assert property (@(posedge clk) disable iff (rst)
        hit_q_o |-> ($past(addr_i[ADDR_W-1:TAG_LO]) == $past(cfg_i))); // R3
endmodule

// File: rtl/pj_hold_flag.sv
module pj_hold_flag (
    input  logic clk,
    input  logic rst,
    input  logic hit_i,
    output logic flag_o,
    output logic flag_nxt_o
);
    import pj_pkg::*;

    bus_mode_e mode_q, mode_d;

    always_comb begin
        mode_d = mode_q;
        if (hit_i) mode_d = MODE_PASS;
    end

    always_ff @(posedge clk) begin
        if (rst) mode_q <= MODE_INJECT;
        else     mode_q <= mode_d;
    end

    assign flag_o     = is_pass(mode_q);
    assign flag_nxt_o = is_pass(mode_d);

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        flag_o |=> flag_o); // R6
endmodule

// File: rtl/pj_data_sel.sv
module pj_data_sel #(
    parameter int              DATA_W = pj_pkg::DEF_DATA_W,
    parameter logic [DATA_W-1:0] NOP  = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pass_nxt_i,
    input  logic [DATA_W-1:0] mem_din_i,
    output logic [DATA_W-1:0] dout_o
);
    // Selected with the next flag value so data and enable switch together
    always_ff @(posedge clk) begin
        if (rst)             dout_o <= NOP;
        else if (pass_nxt_i) dout_o <= mem_din_i;
        else                 dout_o <= NOP;
    end
endmodule

// File: rtl/pj_nop_inject.sv
module pj_nop_inject #(
    parameter int ADDR_W = pj_pkg::DEF_ADDR_W,
    parameter int CFG_W  = pj_pkg::DEF_CFG_W,
    parameter int DATA_W = pj_pkg::DEF_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              addr_vld_i,
    input  logic [CFG_W-1:0]  cfg_i,
    input  logic [DATA_W-1:0] mem_din_i,
    output logic [DATA_W-1:0] cpu_dout_o,
    output logic              bus_en_o
);
    localparam logic [DATA_W-1:0] NOP_BYTE = '0;

    logic hit_q;
    logic flag;
    logic flag_nxt;

    pj_cmp_sync #(.ADDR_W(ADDR_W), .CFG_W(CFG_W)) u_cmp (
        .clk(clk), .rst(rst), .addr_i(addr_i), .addr_vld_i(addr_vld_i),
        .cfg_i(cfg_i), .hit_q_o(hit_q)
    );

    pj_hold_flag u_flag (
        .clk(clk), .rst(rst), .hit_i(hit_q), .flag_o(flag), .flag_nxt_o(flag_nxt)
    );

    pj_data_sel #(.DATA_W(DATA_W), .NOP(NOP_BYTE)) u_sel (
        .clk(clk), .rst(rst), .pass_nxt_i(flag_nxt), .mem_din_i(mem_din_i),
        .dout_o(cpu_dout_o)
    );

    assign bus_en_o = flag;

    AST_FLAG_NEEDS_HIT: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_en_o) |-> $past(hit_q)); // R5

    AST_NOP_WHILE_OFF: assert property (@(posedge clk) disable iff (rst)
        !bus_en_o |-> (cpu_dout_o == NOP_BYTE)); // R2

    AST_MEM_WHILE_ON: assert property (@(posedge clk) disable iff (rst)
        bus_en_o |-> (cpu_dout_o == $past(mem_din_i))); // R7

    AST_SWITCH_TOGETHER: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_en_o) |-> (cpu_dout_o == $past(mem_din_i))); // R8
endmodule

// File: tb/pj_nop_inject_tb.sv
module pj_nop_inject_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] addr = '0;
    logic        vld = 1'b0;
    logic [3:0]  cfg = 4'hB;
    logic [7:0]  mem = 8'h00;
    logic [7:0]  dout;
    logic        ben;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // Behavioural reference: a queue of sampled hits and a sticky integer
    int ref_flag = 0;
    int ref_dout = 0;
    int hit_q[$];

    pj_nop_inject u_dut (
        .clk(clk), .rst(rst), .addr_i(addr), .addr_vld_i(vld), .cfg_i(cfg),
        .mem_din_i(mem), .cpu_dout_o(dout), .bus_en_o(ben)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        if (rst) begin
            ref_flag = 0; ref_dout = 0; hit_q = {0};
        end else begin
            int old_hit;
            old_hit = hit_q.pop_front();
            if (old_hit != 0) ref_flag = 1;
            ref_dout = (ref_flag != 0) ? int'(mem) : 0;
            hit_q.push_back((vld && (addr >> 12) == cfg) ? 1 : 0);
        end
    end

    // Per-cycle comparison against the reference
    always @(negedge clk) begin
        if (!rst && !done) begin
            n_run++;
            if (int'(ben) != ref_flag || int'(dout) != ref_dout) begin
                n_fail++;
                $display("FAIL %s model: ben=%0d dout=%02h expected ben=%0d dout=%02h",
                         (ref_flag != 0) ? "R7" : "R2", ben, dout, ref_flag, ref_dout);
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk); @(negedge clk);
    endtask

    task automatic do_reset;
        @(negedge clk); rst = 1'b1; vld = 1'b0;
        tick(); tick();
        rst = 1'b0;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_fail++; n_run++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        do_reset();
        chk("R1", int'(ben), 0);
        chk("R1", int'(dout), 0);

        // Injection with varied memory data, nonmatching addresses
        cfg = 4'hB;
        for (int i = 0; i < 8; i++) begin
            addr = 16'h9000 + 16'(i); vld = 1'b1; mem = 8'hA5 ^ 8'(i);
            tick();
            chk("R2", int'(dout), 0);
            chk("R2", int'(ben), 0);
        end

        // 9 -> glitch B (strobe low) -> A : must not hand over
        addr = 16'hB000; vld = 1'b0; mem = 8'h3C; tick();
        addr = 16'hA000; vld = 1'b1; tick();
        tick(); tick();
        chk("R4", int'(ben), 0);

        // Only the upper nibble is compared
        addr = 16'h0BFF; vld = 1'b1; tick(); tick(); tick();
        chk("R3", int'(ben), 0);

        // Exact latency: valid match presented now
        addr = 16'hB123; vld = 1'b1; mem = 8'h77;
        tick();                        // edge N: hit sampled
        chk("R5", int'(ben), 0);
        chk("R5", int'(dout), 0);
        addr = 16'hB124; vld = 1'b0; mem = 8'h5E;
        tick();                        // edge N+1: handover
        chk("R5", int'(ben), 1);
        chk("R8", int'(dout), 8'h5E);

        // Sticky across any later input
        for (int i = 0; i < 10; i++) begin
            addr = 16'(i * 16'h1357); vld = i[0]; cfg = 4'(i); mem = 8'(i * 29);
            tick();
            chk("R6", int'(ben), 1);
            chk("R7", int'(dout), (i * 29) & 8'hFF);
        end

        // Reset clears, then every configuration code triggers
        for (int c = 0; c < 16; c++) begin
            do_reset();
            chk("R1", int'(ben), 0);
            cfg = 4'(c); addr = {4'(c), 12'hABC}; vld = 1'b1; mem = 8'(c + 1);
            tick();
            chk("R3", int'(ben), 0);
            vld = 1'b0; tick();
            chk("R3", int'(ben), 1);
            chk("R8", int'(dout), c + 1);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule